// File: doc/BRIEF.md
# Key-Protected Two-Stage Watchdog Timer

This block is a watchdog peripheral on a simple register port. In that port a write takes effect at the clock edge and a read returns data in the same cycle. A down-counter runs only on cycles where the tick-enable input is high. When the counter runs out the first time, the block raises an interrupt and reloads itself from the load register. If the counter runs out again while that interrupt is still pending and the reset stage is armed, the block drives a fixed-length system reset pulse. The reset therefore arrives after two full count periods.

Every configuration write is gated by a key register. Writing the magic key opens the other registers for writing, and writing any other value closes them again. Software keeps the system alive by writing a one to the kick register. That write clears a pending interrupt and restarts the count from the load value.

Top module: `wdg_timer`

## Requirements
- R1: After synchronous reset every register reads zero, the key lock is closed, and `irq` and `sys_rst` are low.
- R2: A write of 0x1ACCE551 to offset 0xC00 opens the lock, and the lock offset then reads 1. A write of any other value there closes it, and the lock offset then reads 0.
- R3: While the lock is closed, writes to every offset other than 0xC00 are ignored. All registers stay readable, and offsets that are not mapped (and the kick offset) read zero.
- R4: The control register at 0x008 has bit 0 as run enable and bit 1 as reset arm. Bits 31:2 always read zero.
- R5: A control write that takes bit 0 from 0 to 1 copies the load register (0x000) into the counter. The live count reads back at 0x004.
- R6: While enabled, the counter drops by one on each cycle with `tick_en` high. A tick that finds the count at zero is an expiry and reloads the counter from the load register, so a load value of N gives N+1 ticks per stage and a load value of 0 expires on the first tick.
- R7: An expiry with no interrupt pending sets `irq`, and `irq` stays high until it is cleared. The status offset 0x014 reads 1 while it is pending and 0 otherwise.
- R8: An expiry while the interrupt is pending and reset is armed drives `sys_rst` high for exactly 16 cycles. When reset is not armed, such an expiry leaves `irq` set and gives no pulse.
- R9: Writing bit 0 = 1 to the kick offset 0x00C clears `irq` and reloads the counter. This takes priority over an expiry in the same cycle. A kick write with bit 0 = 0 has no effect.
- R10: With run enable clear, the counter holds its value and no interrupt or reset is generated.
- R11: The counter is 32 bits wide. A load value of 0xFFFFFFFF is held and counts down from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count enable strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, same cycle |
| irq | output | 1 | Timeout interrupt level |
| sys_rst | output | 1 | System reset pulse |

## Verification
The kick write and a counter expiry can fall in the same cycle. When they do, the kick must win: no interrupt is set, no reset pulse is fired, and the count restarts from the load value. The bench provokes this directly by driving a kick write together with a tick on the exact cycle the count sits at zero, both with and without an interrupt already pending. Random traffic then mixes kicks, ticks, control and lock writes. A cycle-level bench model, built from the requirements, judges `irq`, `sys_rst` and every read after each edge.

// File: rtl/wdg_pkg.sv
// Shared constants for the watchdog: register offsets, unlock key, bus widths.
// Assumes byte offsets on a 12-bit address and a 32-bit data bus.
package wdg_pkg;
    localparam int ADDR_W = 12;
    localparam int BUS_W  = 32;

    localparam logic [ADDR_W-1:0] OFF_LOAD  = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_COUNT = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 12'h008;
    localparam logic [ADDR_W-1:0] OFF_KICK  = 12'h00C;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 12'h014;
    localparam logic [ADDR_W-1:0] OFF_LOCK  = 12'hC00;

    localparam logic [BUS_W-1:0] UNLOCK_KEY = 32'h1ACC_E551;
endpackage

// File: rtl/wdg_keylock.sv
// Write-protection latch: opens on the magic key and closes on any other value.
// Assumes lock_wr pulses for one cycle per bus write to the lock offset.
module wdg_keylock
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_wr,
    input  logic [BUS_W-1:0] wdata,
    output logic             unlocked
);
    logic open_q;

    // Update the open flag on every lock write; closed after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       open_q <= 1'b0;
        else if (lock_wr) open_q <= (wdata == UNLOCK_KEY);
    end

    assign unlocked = open_q;

    a_r2_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_wr && wdata == UNLOCK_KEY) |=> unlocked);
endmodule

// File: rtl/wdg_downcnt.sv
// Tick-driven down-counter with reload; flags expiry when a tick finds zero.
// Assumes reload has priority and suppresses expiry in the same cycle.
module wdg_downcnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             reload,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;
    logic             at_zero;

    assign at_zero = (cnt_q == '0);
    assign expire  = run && tick && at_zero && !reload;

    // Reload on request, otherwise decrement per tick and wrap to the load value.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (reload)          cnt_q <= load_val;
        else if (run && tick)     cnt_q <= at_zero ? load_val : cnt_q - CNT_W'(1);
    end

    assign count = cnt_q;

    a_r6_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !reload && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
    a_r10_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !reload) |=> $stable(cnt_q));
endmodule

// File: rtl/wdg_escalate.sv
// Two-stage escalation: first expiry sets the interrupt, a second expiry with
// the interrupt pending and reset armed fires a fixed-length reset pulse.
// Assumes clear and expiry never coincide (the counter suppresses that case).
module wdg_escalate #(
    parameter int RST_PULSE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clear,
    input  logic rst_arm,
    output logic irq,
    output logic sys_rst
);
    localparam int PW = (RST_PULSE > 1) ? $clog2(RST_PULSE) : 1;

    logic          irq_q;
    logic          pulse_q;
    logic [PW-1:0] left_q;
    logic          fire;

    assign fire = expire && irq_q && rst_arm;

    // Interrupt level: cleared by a kick, set by an expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)      irq_q <= 1'b0;
        else if (clear)  irq_q <= 1'b0;
        else if (expire) irq_q <= 1'b1;
    end

    // Reset pulse stretcher: runs for RST_PULSE cycles from the firing edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            left_q  <= '0;
        end else if (fire) begin
            pulse_q <= 1'b1;
            left_q  <= PW'(RST_PULSE - 1);
        end else if (pulse_q) begin
            if (left_q == '0) pulse_q <= 1'b0;
            else              left_q  <= left_q - PW'(1);
        end
    end

    assign irq     = irq_q;
    assign sys_rst = pulse_q;

    a_r7_first_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !clear) |=> irq_q);
    a_r9_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !irq_q);
    a_r8_second_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && irq_q && rst_arm) |=> pulse_q);
endmodule

// File: rtl/wdg_timer.sv
// Top of the watchdog: register decode, key gating, read mux, and the
// counter/escalation pair. Single-cycle register port with a combinational read.
module wdg_timer
    import wdg_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int RST_PULSE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    output logic              irq,
    output logic              sys_rst
);
    logic             unlocked;
    logic             cfg_wr;
    logic             kick;
    logic             run_rise;
    logic [CNT_W-1:0] load_q;
    logic [1:0]       ctrl_q;
    logic [CNT_W-1:0] count;
    logic             expire;

    assign cfg_wr   = wr_en && unlocked && (addr != OFF_LOCK);
    assign kick     = cfg_wr && (addr == OFF_KICK) && wdata[0];
    assign run_rise = cfg_wr && (addr == OFF_CTRL) && wdata[0] && !ctrl_q[0];

    wdg_keylock u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_wr  (wr_en && addr == OFF_LOCK),
        .wdata    (wdata),
        .unlocked (unlocked)
    );

    // Load and control registers, written only while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q <= '0;
            ctrl_q <= '0;
        end else if (cfg_wr) begin
            if (addr == OFF_LOAD) load_q <= wdata[CNT_W-1:0];
            if (addr == OFF_CTRL) ctrl_q <= wdata[1:0];
        end
    end

    wdg_downcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ctrl_q[0]),
        .tick     (tick_en),
        .reload   (kick || run_rise),
        .load_val (load_q),
        .count    (count),
        .expire   (expire)
    );

    wdg_escalate #(.RST_PULSE(RST_PULSE)) u_esc (
        .clk     (clk),
        .rst_n   (rst_n),
        .expire  (expire),
        .clear   (kick),
        .rst_arm (ctrl_q[1]),
        .irq     (irq),
        .sys_rst (sys_rst)
    );

    // Read mux: every register visible regardless of the lock.
    always_comb begin
        unique case (addr)
            OFF_LOAD:  rdata = BUS_W'(load_q);
            OFF_COUNT: rdata = BUS_W'(count);
            OFF_CTRL:  rdata = BUS_W'(ctrl_q);
            OFF_STAT:  rdata = BUS_W'(irq);
            OFF_LOCK:  rdata = BUS_W'(unlocked);
            default:   rdata = '0;
        endcase
    end

    a_r3_locked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !unlocked && addr != OFF_LOCK) |=> ($stable(load_q) && $stable(ctrl_q)));
    a_r5_enable_loads: assert property (@(posedge clk) disable iff (!rst_n)
        run_rise |=> (count == $past(load_q)));
endmodule

// File: tb/sim_wdg_timer.sv
// Self-checking bench: directed corners plus seeded random traffic against a
// cycle model written from the requirements.
module sim_wdg_timer;
    import wdg_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic        sys_rst;

    int tests = 0;
    int fails = 0;

    // Requirement model state
    logic [31:0] m_load, m_cnt;
    bit          m_en, m_arm, m_irq, m_unl;
    int          m_left;

    always #4 clk = ~clk;

    wdg_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .sys_rst(sys_rst)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [11:0] a);
        case (a)
            OFF_COUNT: return "R6";
            OFF_CTRL:  return "R4";
            OFF_STAT:  return "R7";
            OFF_LOCK:  return "R2";
            default:   return "R3";
        endcase
    endfunction

    function automatic logic [31:0] exp_rd(input logic [11:0] a);
        case (a)
            OFF_LOAD:  return m_load;
            OFF_COUNT: return m_cnt;
            OFF_CTRL:  return {30'b0, m_arm, m_en};
            OFF_STAT:  return {31'b0, m_irq};
            OFF_LOCK:  return {31'b0, m_unl};
            default:   return 32'h0;
        endcase
    endfunction

    // Apply one clock edge to the model, following the requirements.
    task automatic model(input bit w, input logic [11:0] a, input logic [31:0] d, input bit t);
        bit cfg, kick, rise, exp_ev, fire;
        cfg    = w && m_unl && (a != OFF_LOCK);
        kick   = cfg && a == OFF_KICK && d[0];
        rise   = cfg && a == OFF_CTRL && d[0] && !m_en;
        exp_ev = m_en && t && m_cnt == 0 && !kick && !rise;
        fire   = exp_ev && m_irq && m_arm;
        if (fire) m_left = 16;
        else if (m_left > 0) m_left--;
        if (kick) m_irq = 0;
        else if (exp_ev) m_irq = 1;
        if (kick || rise) m_cnt = m_load;
        else if (m_en && t) m_cnt = (m_cnt == 0) ? m_load : m_cnt - 1;
        if (cfg && a == OFF_LOAD) m_load = d;
        if (cfg && a == OFF_CTRL) begin m_en = d[0]; m_arm = d[1]; end
        if (w && a == OFF_LOCK) m_unl = (d == UNLOCK_KEY);
    endtask

    task automatic cyc(input bit w, input logic [11:0] a, input logic [31:0] d, input bit t);
        wr_en = w; addr = a; wdata = d; tick_en = t;
        @(posedge clk);
        model(w, a, d, t);
        @(negedge clk);
        chk("R7", {31'b0, irq}, {31'b0, m_irq});
        chk("R8", {31'b0, sys_rst}, {31'b0, (m_left > 0)});
        if (!w) chk(tag_of(a), rdata, exp_rd(a));
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d); cyc(1, a, d, 0); endtask
    task automatic rd(input logic [11:0] a); cyc(0, a, 0, 0); endtask
    task automatic tk(input int n); for (int i = 0; i < n; i++) cyc(0, OFF_COUNT, 0, 1); endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n;
        logic [11:0] ra;
        m_load = 0; m_cnt = 0; m_en = 0; m_arm = 0; m_irq = 0; m_unl = 0; m_left = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1", {30'b0, irq, sys_rst}, 32'h0);
        rd(OFF_LOAD);  chk("R1", rdata, 0);
        rd(OFF_COUNT); chk("R1", rdata, 0);
        rd(OFF_CTRL);  chk("R1", rdata, 0);
        rd(OFF_STAT);  chk("R1", rdata, 0);
        rd(OFF_LOCK);  chk("R1", rdata, 0);

        // R3: writes ignored while locked
        wr(OFF_LOAD, 5); wr(OFF_CTRL, 1); tk(3);
        rd(OFF_LOAD); chk("R3", rdata, 0);
        rd(OFF_CTRL); chk("R3", rdata, 0);

        // R2: unlock with the key
        wr(OFF_LOCK, UNLOCK_KEY);
        rd(OFF_LOCK); chk("R2", rdata, 1);

        // R4: reserved control bits read zero
        wr(OFF_CTRL, 32'hFFFF_FFFC);
        rd(OFF_CTRL); chk("R4", rdata, 0);
        wr(OFF_LOAD, 3); wr(OFF_CTRL, 3);
        rd(OFF_CTRL); chk("R4", rdata, 3);
        rd(OFF_COUNT); chk("R5", rdata, 3);

        // R6/R7: first expiry after load+1 ticks
        tk(3); chk("R6", {31'b0, irq}, 0);
        rd(OFF_COUNT); chk("R6", rdata, 0);
        tk(1); chk("R7", {31'b0, irq}, 1);
        rd(OFF_STAT); chk("R7", rdata, 1);
        rd(OFF_COUNT); chk("R6", rdata, 3);

        // R8: second expiry fires a 16-cycle reset
        tk(3); chk("R8", {31'b0, sys_rst}, 0);
        tk(1); chk("R8", {31'b0, sys_rst}, 1);
        n = 1;
        while (sys_rst && n < 40) begin rd(OFF_COUNT); if (sys_rst) n++; end
        chk("R8", n, 16);
        chk("R8", {31'b0, irq}, 1);

        // R9: kick clears, and wins against a same-cycle expiry
        wr(OFF_KICK, 1); chk("R9", {31'b0, irq}, 0);
        tk(3); cyc(1, OFF_KICK, 1, 1);
        chk("R9", {31'b0, irq}, 0);
        rd(OFF_COUNT); chk("R9", rdata, 3);
        tk(4); chk("R9", {31'b0, irq}, 1);
        tk(3); cyc(1, OFF_KICK, 1, 1);
        chk("R9", {30'b0, irq, sys_rst}, 0);
        tk(1); wr(OFF_KICK, 2);
        rd(OFF_COUNT); chk("R9", rdata, 2);

        // R8: reset disarmed gives no pulse
        wr(OFF_CTRL, 1); tk(3); chk("R8", {31'b0, irq}, 1);
        tk(4); chk("R8", {30'b0, irq, sys_rst}, 32'h2);

        // R10: disabled counter holds
        wr(OFF_KICK, 1); wr(OFF_CTRL, 0); tk(10);
        rd(OFF_COUNT); chk("R10", rdata, 3);
        chk("R10", {31'b0, irq}, 0);

        // R6: load zero expires on the first tick
        wr(OFF_LOAD, 0); wr(OFF_CTRL, 1); tk(1);
        chk("R6", {31'b0, irq}, 1);

        // R11: full 32-bit range
        wr(OFF_KICK, 1); wr(OFF_CTRL, 0); wr(OFF_LOAD, 32'hFFFF_FFFF); wr(OFF_CTRL, 1);
        rd(OFF_COUNT); chk("R11", rdata, 32'hFFFF_FFFF);
        tk(1); rd(OFF_COUNT); chk("R11", rdata, 32'hFFFF_FFFE);

        // R2/R3: any other lock value closes the lock
        wr(OFF_LOCK, 32'h1ACC_E550);
        rd(OFF_LOCK); chk("R2", rdata, 0);
        wr(OFF_LOAD, 7);
        rd(OFF_LOAD); chk("R3", rdata, 32'hFFFF_FFFF);

        // Random traffic with a fixed seed
        void'($urandom(32'd2024));
        wr(OFF_LOCK, UNLOCK_KEY); wr(OFF_CTRL, 0); wr(OFF_LOAD, 4); wr(OFF_CTRL, 3);
        for (int i = 0; i < 4000; i++) begin
            int  r;
            bit  t;
            r = $urandom % 20;
            t = ($urandom % 3) != 0;
            case (r)
                0: cyc(1, OFF_LOCK, ($urandom % 4 == 0) ? (UNLOCK_KEY ^ (32'h1 << ($urandom % 32))) : UNLOCK_KEY, t);
                1, 2: cyc(1, OFF_KICK, $urandom % 2, t);
                3: cyc(1, OFF_LOAD, $urandom % 6, t);
                4: cyc(1, OFF_CTRL, $urandom % 4, t);
                default: begin
                    case ($urandom % 7)
                        0: ra = OFF_LOAD;
                        1: ra = OFF_CTRL;
                        2: ra = OFF_STAT;
                        3: ra = OFF_LOCK;
                        4: ra = 12'h010;
                        default: ra = OFF_COUNT;
                    endcase
                    cyc(0, ra, 0, t);
                end
            endcase
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule